// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo serial audio from an external source that supplies both the bit clock and the LR (word-select) clock. The block only receives. It never drives either clock. A 3-bit format code chooses how the data words sit in each LR half-period: right-justified at 16, 20 or 24 bits, left-justified at 20 bits, or I2S at 16 or 20 bits. In every format the words are two's complement and arrive MSB first. Each completed word leaves the block as a 24-bit sign-extended sample. The sample comes with a one-cycle valid strobe and a flag that marks the left channel.

The bit clock is also the block clock, and serial data and LR clock are sampled on its rising edge. The format code is loaded only while power-down is high. Power-down also discards any partial word, so every release from power-down starts word alignment again. Codes that do not name a format keep the receiver silent.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is low, and after it rises with no further stimulus, `sample_out` is zero and `sample_valid` and `sample_left` are low.
- R2: `fmt_sel` is loaded only on rising edges where `pwr_down` is high. A change of `fmt_sel` while `pwr_down` is low has no effect on the received words. Codes: 0 = right-justified 16-bit, 1 = right-justified 20-bit, 2 = left-justified 20-bit, 3 = I2S 16/20-bit, 4 = right-justified 24-bit.
- R3: In code 0, the rising edge that first sees a new LR level emits the 16 bits sampled on the 16 preceding rising edges, sign-extended to 24 bits. The word belongs to the old LR level, and LR high means left.
- R4: Codes 1 and 4 behave as R3 with 20-bit and 24-bit words. Bits above the word width copy its MSB.
- R5: In a right-justified mode, the first LR change after power-down is released emits nothing.
- R6: In code 2, the MSB is the bit sampled on the edge that sees the LR change. The word is emitted after its 20th bit, and LR high means left.
- R7: In code 2, a half-period with fewer than 20 bits before the next LR change emits nothing.
- R8: In code 3, the MSB is sampled one rising edge after the LR change, and LR low means left. A 20-bit word is emitted after its 20th bit, whether that bit falls inside the half-period or on the edge of the next LR change.
- R9: In code 3, when the next LR change is seen together with the 16th bit (32 bit clocks per frame), a 16-bit word is emitted sign-extended.
- R10: Codes 5, 6 and 7 never raise `sample_valid`.
- R11: While `pwr_down` is high no strobe is produced, and a word not yet complete when it rises is dropped.
- R12: `sample_valid` is high for exactly one cycle per word. It rises in the cycle after the rising edge that sampled the word's completing LR change or last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, also the block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Power-down, high loads the format and halts reception |
| fmt_sel | input | 3 | Format code |
| lr_clk | input | 1 | LR word-select clock |
| ser_data | input | 1 | Serial audio data |
| sample_out | output | 24 | Received word, sign-extended |
| sample_valid | output | 1 | One-cycle strobe for a new word |
| sample_left | output | 1 | High when the word belongs to the left channel |

## Verification
The hardest case to reach is I2S with exactly 16 bit clocks per half-period. There the word's LSB comes in on the very edge that shows the next LR change, so the receiver must finish the word and restart in the same cycle. The bench reaches it by building each I2S half-period with the previous word's LSB carried into its first slot. It runs this at 16, 20 and 32 bit clocks per half-period, so all three completion paths are taken. Power-down framing between vectors holds the LR level, so the LR edge where reception starts is always known.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SMP_W   = 24;
    localparam int CNT_W   = $clog2(SMP_W + 1);
    localparam int W_SHORT = 16;
    localparam int W_MID   = 20;
    localparam int W_LONG  = 24;

    typedef enum logic [1:0] {
        JK_RIGHT = 2'd0,
        JK_LEFT  = 2'd1,
        JK_I2S   = 2'd2,
        JK_OFF   = 2'd3
    } just_e;

    typedef struct packed {
        just_e            kind;
        logic [CNT_W-1:0] len;
        logic             left_lvl;
    } fmt_cfg_t;

    typedef struct packed {
        logic             lr;
        logic             synced;
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [SMP_W-1:0] sr;
        logic [SMP_W-1:0] word;
        logic             valid;
        logic             left;
    } eng_st_t;

    function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
        fmt_cfg_t c;
        c.kind     = JK_OFF;
        c.len      = CNT_W'(W_SHORT);
        c.left_lvl = 1'b1;
        case (code)
            3'd0: begin c.kind = JK_RIGHT; c.len = CNT_W'(W_SHORT); end
            3'd1: begin c.kind = JK_RIGHT; c.len = CNT_W'(W_MID);   end
            3'd2: begin c.kind = JK_LEFT;  c.len = CNT_W'(W_MID);   end
            3'd3: begin c.kind = JK_I2S;   c.len = CNT_W'(W_MID); c.left_lvl = 1'b0; end
            3'd4: begin c.kind = JK_RIGHT; c.len = CNT_W'(W_LONG);  end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic [SMP_W-1:0] sign_fill(input logic [SMP_W-1:0] w,
                                                   input logic [CNT_W-1:0] n);
        logic [SMP_W-1:0] r;
        logic             s;
        s = w[n - CNT_W'(1)];
        for (int i = 0; i < SMP_W; i++) begin
            r[i] = (i < int'(n)) ? w[i] : s;
        end
        return r;
    endfunction

endpackage

// File: rtl/aud_rx_cfg.sv
module aud_rx_cfg
    import aud_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic [2:0] fmt_sel,
    output fmt_cfg_t   cfg_o
);

    fmt_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (pwr_down) begin
            cfg_d = decode_fmt(fmt_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= decode_fmt(3'd0);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // Format only moves while power-down is high (R2)
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down |=> $stable(cfg_q));

endmodule

// File: rtl/aud_rx_engine.sv
module aud_rx_engine
    import aud_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  fmt_cfg_t         cfg_i,
    input  logic             lr_clk,
    input  logic             ser_data,
    output logic [SMP_W-1:0] word_o,
    output logic             valid_o,
    output logic             left_o
);

    eng_st_t          st_d, st_q;
    logic [SMP_W-1:0] shifted;
    logic [CNT_W-1:0] cnt_inc;
    logic             lr_chg;
    logic             short_hit;
    logic             mid_hit;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        shifted    = {st_q.sr[SMP_W-2:0], ser_data};
        cnt_inc    = st_q.cnt + CNT_W'(1);
        lr_chg     = (lr_clk != st_q.lr);
        short_hit  = (st_q.cnt == CNT_W'(W_SHORT - 1));
        mid_hit    = (st_q.cnt == CNT_W'(W_MID - 1));
        st_d.lr    = lr_clk;
        st_d.sr    = shifted;

        if (pwr_down || cfg_i.kind == JK_OFF) begin
            st_d.synced = 1'b0;
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else begin
            case (cfg_i.kind)
                JK_RIGHT: begin
                    // word is the history before this edge's bit
                    if (lr_chg) begin
                        st_d.synced = 1'b1;
                        if (st_q.synced) begin
                            st_d.valid = 1'b1;
                            st_d.word  = sign_fill(st_q.sr, cfg_i.len);
                            st_d.left  = (st_q.lr == cfg_i.left_lvl);
                        end
                    end
                end
                JK_LEFT: begin
                    if (lr_chg) begin
                        st_d.active = 1'b1;
                        st_d.cnt    = CNT_W'(1);
                    end else if (st_q.active) begin
                        st_d.cnt = cnt_inc;
                        if (cnt_inc == cfg_i.len) begin
                            st_d.active = 1'b0;
                            st_d.valid  = 1'b1;
                            st_d.word   = sign_fill(shifted, cfg_i.len);
                            st_d.left   = (lr_clk == cfg_i.left_lvl);
                        end
                    end
                end
                JK_I2S: begin
                    if (lr_chg) begin
                        // LSB of the old word may ride on this edge
                        if (st_q.active && (short_hit || mid_hit)) begin
                            st_d.valid = 1'b1;
                            st_d.word  = sign_fill(shifted, cnt_inc);
                            st_d.left  = (st_q.lr == cfg_i.left_lvl);
                        end
                        st_d.active = 1'b1;
                        st_d.cnt    = '0;
                    end else if (st_q.active) begin
                        st_d.cnt = cnt_inc;
                        if (cnt_inc == cfg_i.len) begin
                            st_d.active = 1'b0;
                            st_d.valid  = 1'b1;
                            st_d.word   = sign_fill(shifted, cfg_i.len);
                            st_d.left   = (lr_clk == cfg_i.left_lvl);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;
    assign left_o  = st_q.left;

    assert_codes_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.kind == JK_OFF) |=> !st_q.valid);

    assert_pd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !st_q.valid);

    assert_rj_on_lr_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(cfg_i.kind == JK_RIGHT)) |-> (st_q.lr != $past(st_q.lr)));

    assert_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(cfg_i.len) != CNT_W'(W_LONG)) |->
        ($countones(st_q.word[SMP_W-1:W_MID-1]) == 0 ||
         $countones(st_q.word[SMP_W-1:W_MID-1]) == (SMP_W - W_MID + 1)));

    assert_lj_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(cfg_i.kind == JK_LEFT)) |-> (st_q.left == st_q.lr));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
(
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic [2:0]       fmt_sel,
    input  logic             lr_clk,
    input  logic             ser_data,
    output logic [SMP_W-1:0] sample_out,
    output logic             sample_valid,
    output logic             sample_left
);

    fmt_cfg_t cfg;

    aud_rx_cfg u_cfg (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .fmt_sel  (fmt_sel),
        .cfg_o    (cfg)
    );

    aud_rx_engine u_engine (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .cfg_i    (cfg),
        .lr_clk   (lr_clk),
        .ser_data (ser_data),
        .word_o   (sample_out),
        .valid_o  (sample_valid),
        .left_o   (sample_left)
    );

endmodule

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    logic        bit_clk;
    logic        rst_n;
    logic        pwr_down;
    logic [2:0]  fmt_sel;
    logic        lr_clk;
    logic        ser_data;
    logic [23:0] sample_out;
    logic        sample_valid;
    logic        sample_left;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int n_cap = 0;
    logic [23:0] cap_v [8];
    logic        cap_l [8];
    int          cap_t [8];

    // {code, bits per half, left word, right word}
    localparam logic [59:0] VEC [NVEC] = '{
        {4'd0, 8'd16, 24'h008001, 24'h007FFE},
        {4'd0, 8'd32, 24'h001234, 24'h00FEDC},
        {4'd1, 8'd20, 24'h080000, 24'h07FFFF},
        {4'd1, 8'd32, 24'h012345, 24'h0ABCDE},
        {4'd4, 8'd24, 24'h800000, 24'h7FFFFF},
        {4'd4, 8'd32, 24'hC0FFEE, 24'h123456},
        {4'd2, 8'd20, 24'h09ABCD, 24'h013579},
        {4'd2, 8'd32, 24'h07A5A5, 24'h085A5A},
        {4'd3, 8'd16, 24'h008421, 24'h007BDE},
        {4'd3, 8'd20, 24'h0F0F0F, 24'h00F0F0},
        {4'd3, 8'd32, 24'h080001, 24'h03FFFE}
    };

    aud_serial_rx dut (
        .bit_clk      (bit_clk),
        .rst_n        (rst_n),
        .pwr_down     (pwr_down),
        .fmt_sel      (fmt_sel),
        .lr_clk       (lr_clk),
        .ser_data     (ser_data),
        .sample_out   (sample_out),
        .sample_valid (sample_valid),
        .sample_left  (sample_left)
    );

    initial bit_clk = 1'b0;
    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    always @(posedge bit_clk) cyc <= cyc + 1;

    always @(negedge bit_clk) begin
        if (rst_n && sample_valid) begin
            if (n_cap < 8) begin
                cap_v[n_cap] = sample_out;
                cap_l[n_cap] = sample_left;
                cap_t[n_cap] = cyc;
            end
            n_cap = n_cap + 1;
        end
    end

    function automatic int word_len(input int code, input int slot);
        case (code)
            1, 2: return 20;
            3: return (slot == 16) ? 16 : 20;
            4: return 24;
            default: return 16;
        endcase
    endfunction

    function automatic logic [23:0] sx(input logic [23:0] v, input int n);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
        return r;
    endfunction

    function automatic logic gen_bit(input int code, input int slot, input int n,
                                     input logic [23:0] v, input int i, input logic carry);
        int k;
        if (code == 2) return (i < n) ? v[n-1-i] : 1'b0;
        if (code == 3) begin
            if (i == 0) return carry;
            return (i <= n) ? v[n-i] : 1'b0;
        end
        k = slot - 1 - i;
        return (k < n) ? v[k] : 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_half(input int code, input int slot, input logic lvl,
                             input logic [23:0] v, inout logic carry);
        int n;
        logic c_in;
        n = word_len(code, slot);
        c_in = carry;
        for (int i = 0; i < slot; i++) begin
            @(negedge bit_clk);
            lr_clk = lvl;
            ser_data = gen_bit(code, slot, n, v, i, c_in);
        end
        carry = (code == 3 && slot == n) ? v[0] : 1'b0;
    endtask

    task automatic run_vec(input int code, input int slot, input logic [23:0] lv,
                           input logic [23:0] rv, input bit alt, input logic [2:0] alt_code,
                           input bit pd_tail, output int t_tail);
        logic lf;
        logic carry;
        lf = (code == 3) ? 1'b0 : 1'b1;
        @(negedge bit_clk);
        pwr_down = 1'b1;
        fmt_sel = 3'(code);
        lr_clk = ~lf;
        ser_data = 1'b0;
        repeat (3) @(negedge bit_clk);
        pwr_down = 1'b0;
        if (alt) fmt_sel = alt_code;
        n_cap = 0;
        carry = 1'b0;
        send_half(code, slot, ~lf, 24'h0, carry);
        send_half(code, slot, lf, lv, carry);
        send_half(code, slot, ~lf, rv, carry);
        @(negedge bit_clk);
        if (pd_tail) pwr_down = 1'b1;
        lr_clk = lf;
        ser_data = carry;
        t_tail = cyc;
        @(negedge bit_clk);
        ser_data = 1'b0;
        repeat (3) @(negedge bit_clk);
    endtask

    task automatic check_pair(input string req, input int n, input logic [23:0] lv,
                              input logic [23:0] rv);
        check(req, 32'(n_cap), 32'd2);
        check(req, {7'd0, cap_l[0], cap_v[0]}, {7'd0, 1'b1, sx(lv, n)});
        check(req, {7'd0, cap_l[1], cap_v[1]}, {7'd0, 1'b0, sx(rv, n)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int t_tail;
        rst_n = 1'b0;
        pwr_down = 1'b1;
        fmt_sel = 3'd0;
        lr_clk = 1'b1;
        ser_data = 1'b0;
        repeat (3) @(negedge bit_clk);
        // R1 reset state
        check("R1 reset", {6'd0, sample_valid, sample_left, sample_out}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge bit_clk);
        check("R1 after release", {6'd0, sample_valid, sample_left, sample_out}, 32'd0);

        // table walk: R3 R4 R5 (count) R6 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            int code;
            int slot;
            string req;
            code = int'(VEC[v][59:56]);
            slot = int'(VEC[v][55:48]);
            case (code)
                0: req = "R3 R5";
                1, 4: req = "R4 R5";
                2: req = "R6";
                default: req = (slot == 16) ? "R9" : "R8";
            endcase
            run_vec(code, slot, VEC[v][47:24], VEC[v][23:0], 1'b0, 3'd0, 1'b0, t_tail);
            check_pair(req, word_len(code, slot), VEC[v][47:24], VEC[v][23:0]);
            if (v == 0) begin
                // R12: strobe in the cycle after the edge that saw the LR change
                check("R12 timing", 32'(cap_t[1]), 32'(t_tail + 1));
            end
        end

        // R2: format change while running is ignored
        run_vec(0, 16, 24'h008001, 24'h007FFE, 1'b1, 3'd3, 1'b0, t_tail);
        check_pair("R2", 16, 24'h008001, 24'h007FFE);

        // R7: left-justified half too short
        run_vec(2, 12, 24'h0ABCDE, 24'h012345, 1'b0, 3'd0, 1'b0, t_tail);
        check("R7 short half", 32'(n_cap), 32'd0);

        // R10: unused codes stay silent
        for (int c = 5; c < 8; c++) begin
            run_vec(c, 32, 24'h00F00F, 24'h00ABCD, 1'b0, 3'd0, 1'b0, t_tail);
            check("R10 unused code", 32'(n_cap), 32'd0);
        end

        // R11: power-down before the closing LR change drops the right word
        run_vec(0, 16, 24'h00C3A5, 24'h005A3C, 1'b0, 3'd0, 1'b1, t_tail);
        check("R11 count", 32'(n_cap), 32'd1);
        check("R11 left word", {7'd0, cap_l[0], cap_v[0]}, {7'd0, 1'b1, sx(24'h00C3A5, 16)});

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule